// File: doc/BRIEF.md
# Byte-wide EEPROM access controller with ownership lock

This block lets several requesters on one register port reach a byte-addressed EEPROM one byte per command. A requester first takes an ownership lock. It then loads the data register (for a write) and writes the command register with the start bit set. The controller holds that bit high while the access runs and drops it when the access ends. If the device does not answer, the controller raises a sticky timeout flag instead.

The serial device is replaced by an internal byte array. Its answer arrives a programmable number of cycles after the start. A presence input can mark the device as missing. The command address field covers an 8192-byte space. Only the lower `MEM_BYTES` addresses are populated, and an access above them gets no answer.

Register offsets on `addr_i`: command at 0x0, data at 0x4, lock at 0x8. Reads return data in the same cycle. Writes take effect at the clock edge.

Top module: `eep_access_ctrl`

## Requirements
- R1: After reset, the command, data and lock registers all read 0.
- R2: Writing 1 in bit 5 of the lock register while it is free makes the writer's `rid_i` the owner, and the owner then reads 0x20 from it. While the lock is held, any other requester reads 0 from it, and its writes of bit 5 change nothing.
- R3: Only the owner can free the lock, by writing a value with bit 5 clear. Such a write from any other requester leaves the lock held.
- R4: Writes to the command or data register from a requester that does not hold the lock are ignored. Busy stays 0 and the array is not touched.
- R5: A write command stores the data-register byte at the address in bits 12:0. A write command has bit 31 set and bits 29:28 equal to 11.
- R6: When a read command (bits 29:28 not 11) completes, the data register holds the addressed byte in bits 7:0 and zeros in bits 31:8.
- R7: With a response delay D below `TIMEOUT_CYC`, busy (bit 31) reads 1 for exactly D+1 cycles after the command edge, and the timeout flag stays 0.
- R8: If the device is absent or D is at least `TIMEOUT_CYC`, busy reads 1 for exactly `TIMEOUT_CYC` cycles. Busy then clears, bit 17 sets, and a timed-out write leaves the array unchanged.
- R9: Bit 17 is sticky: later commands with bit 17 at 0 keep it set. A command-register write with bit 17 at 1 clears it.
- R10: While busy is 1, writes to the command and data registers are ignored.
- R11: An access to an address at or above `MEM_BYTES` times out like an absent device.
- R12: The command register reads back the address in bits 12:0 and the write-select bits 29:28 of the last accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register byte offset |
| rid_i | input | ID_W | Requester identity |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| dev_present_i | input | 1 | Modelled device present |
| resp_delay_i | input | DLY_W | Modelled device answer delay in cycles |

## Verification
A wrong sequencer count shows up on the first command of any test as a busy window one cycle too long or too short. A sequencer that never leaves busy freezes every later command, so the next poll loop fails to end. A lock owner that is lost or overwritten appears at once in the lock read-back seen by each requester. It also shows when a later command's effect on the array is missing or unexpected. A dropped capture of the read byte is seen on the data read that follows completion.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] OFF_CMD  = 4'h0;
  localparam logic [3:0] OFF_DATA = 4'h4;
  localparam logic [3:0] OFF_LOCK = 4'h8;

  localparam int BIT_BUSY = 31;
  localparam int BIT_TOUT = 17;
  localparam int BIT_LOCK = 5;
  localparam int EA_W     = 13;
  localparam logic [1:0] WR_SEL = 2'b11;
endpackage

// File: rtl/eep_lock.sv
module eep_lock #(
  parameter int ID_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [ID_W-1:0] rid_i,
  input  logic            bit_i,
  output logic            held_o,
  output logic [ID_W-1:0] owner_o
);
  logic            held_q;
  logic [ID_W-1:0] owner_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else if (wr_i) begin
      if (!held_q && bit_i) begin
        held_q  <= 1'b1;
        owner_q <= rid_i;
      end else if (held_q && rid_i == owner_q && !bit_i) begin
        held_q <= 1'b0;
      end
    end
  end

  assign held_o  = held_q;
  assign owner_o = owner_q;

  p_release_by_owner_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(held_q) |-> $past(wr_i && !bit_i && rid_i == owner_q));
  p_owner_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && $past(held_q)) |-> $stable(owner_q));
endmodule

// File: rtl/eep_seq.sv
module eep_seq #(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_i,
  input  logic tout_clr_i,
  output logic busy_o,
  output logic tout_o,
  output logic abort_o,
  output logic done_o
);
  localparam int TC_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TC_W-1:0] TC_LAST = TC_W'(TIMEOUT_CYC - 1);

  logic            busy_q, tout_q;
  logic [TC_W-1:0] tcnt_q;

  assign abort_o = busy_q && !ack_i && tcnt_q == TC_LAST;
  assign done_o  = busy_q && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tout_q <= 1'b0;
      tcnt_q <= '0;
    end else if (busy_q) begin
      if (ack_i) begin
        busy_q <= 1'b0;
      end else if (tcnt_q == TC_LAST) begin
        busy_q <= 1'b0;
        tout_q <= 1'b1;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end else begin
      if (tout_clr_i) tout_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        tcnt_q <= '0;
      end
    end
  end

  assign busy_o = busy_q;
  assign tout_o = tout_q;

  p_tcnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (32'(tcnt_q) < TIMEOUT_CYC));
  p_tout_ends_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tout_q) |-> !busy_q);
  p_done_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
endmodule

// File: rtl/eep_dev_model.sv
module eep_dev_model #(
  parameter int MEM_BYTES = 1024,
  parameter int DLY_W     = 8,
  parameter int EA_W      = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [EA_W-1:0]  start_addr_i,
  input  logic             start_wr_i,
  input  logic             abort_i,
  input  logic             present_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [7:0]       wdata_i,
  output logic             ack_o,
  output logic [7:0]       rdata_o
);
  localparam int IDX_W = $clog2(MEM_BYTES);

  logic [7:0]       mem [MEM_BYTES];
  logic             active_q, wr_q;
  logic [DLY_W-1:0] dcnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             in_range;

  assign in_range = 32'(start_addr_i) < MEM_BYTES;
  assign ack_o    = active_q && dcnt_q == '0;
  assign rdata_o  = mem[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      dcnt_q   <= '0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= present_i && in_range;
      wr_q     <= start_wr_i;
      dcnt_q   <= delay_i;
      idx_q    <= start_addr_i[IDX_W-1:0];
    end else if (abort_i || ack_o) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      dcnt_q <= dcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ack_o && wr_q) mem[idx_q] <= wdata_i;
  end

  p_ack_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
endmodule

// File: rtl/eep_access_ctrl.sv
module eep_access_ctrl
  import eep_pkg::*;
#(
  parameter int MEM_BYTES   = 1024,
  parameter int TIMEOUT_CYC = 16,
  parameter int ID_W        = 2,
  parameter int DLY_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [3:0]       addr_i,
  input  logic [ID_W-1:0]  rid_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             dev_present_i,
  input  logic [DLY_W-1:0] resp_delay_i
);
  logic            lock_held;
  logic [ID_W-1:0] lock_owner;
  logic            is_owner, busy, tout, abort, done, ack;
  logic            cmd_wr_ok, data_wr_ok, lock_wr, start;
  logic [EA_W-1:0] ea_q;
  logic            wr_q;
  logic [7:0]      data_q, dev_rdata;

  assign is_owner   = lock_held && lock_owner == rid_i;
  assign lock_wr    = req_i && we_i && addr_i == OFF_LOCK;
  assign cmd_wr_ok  = req_i && we_i && addr_i == OFF_CMD  && is_owner && !busy;
  assign data_wr_ok = req_i && we_i && addr_i == OFF_DATA && is_owner && !busy;
  assign start      = cmd_wr_ok && wdata_i[BIT_BUSY];

  eep_lock #(.ID_W(ID_W)) u_lock (
    .clk_i, .rst_ni,
    .wr_i   (lock_wr),
    .rid_i  (rid_i),
    .bit_i  (wdata_i[BIT_LOCK]),
    .held_o (lock_held),
    .owner_o(lock_owner)
  );

  eep_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk_i, .rst_ni,
    .start_i   (start),
    .ack_i     (ack),
    .tout_clr_i(cmd_wr_ok && wdata_i[BIT_TOUT]),
    .busy_o    (busy),
    .tout_o    (tout),
    .abort_o   (abort),
    .done_o    (done)
  );

  eep_dev_model #(.MEM_BYTES(MEM_BYTES), .DLY_W(DLY_W), .EA_W(EA_W)) u_dev (
    .clk_i, .rst_ni,
    .start_i     (start),
    .start_addr_i(wdata_i[EA_W-1:0]),
    .start_wr_i  (wdata_i[29:28] == WR_SEL),
    .abort_i     (abort),
    .present_i   (dev_present_i),
    .delay_i     (resp_delay_i),
    .wdata_i     (data_q),
    .ack_o       (ack),
    .rdata_o     (dev_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_q   <= '0;
      wr_q   <= 1'b0;
      data_q <= '0;
    end else begin
      if (cmd_wr_ok) begin
        ea_q <= wdata_i[EA_W-1:0];
        wr_q <= wdata_i[29:28] == WR_SEL;
      end
      if (data_wr_ok)          data_q <= wdata_i[7:0];
      else if (done && !wr_q)  data_q <= dev_rdata;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        OFF_CMD: begin
          rdata_o[BIT_BUSY]   = busy;
          rdata_o[29:28]      = {2{wr_q}};
          rdata_o[BIT_TOUT]   = tout;
          rdata_o[EA_W-1:0]   = ea_q;
        end
        OFF_DATA: rdata_o[7:0]     = data_q;
        OFF_LOCK: rdata_o[BIT_LOCK] = is_owner;
        default:  rdata_o = '0;
      endcase
    end
  end

  p_start_needs_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(lock_held && lock_owner == rid_i && req_i && we_i));
  p_data_frozen_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && !$past(done)) |-> $stable(data_q));
endmodule

// File: tb/eep_access_ctrl_tb.sv
module eep_access_ctrl_tb;
  localparam int MEM_BYTES = 1024;
  localparam int TOUT      = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  rid = '0;
  logic [31:0] wdata = '0, rdata;
  logic        present = 1'b1;
  logic [7:0]  dly = '0;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  eep_access_ctrl #(.MEM_BYTES(MEM_BYTES), .TIMEOUT_CYC(TOUT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .rid_i(rid), .wdata_i(wdata), .rdata_o(rdata),
    .dev_present_i(present), .resp_delay_i(dly)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] id, logic [3:0] off, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; rid = id; addr = off; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [1:0] id, logic [3:0] off, output logic [31:0] d);
    req = 1'b1; we = 1'b0; rid = id; addr = off;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic poll(logic [1:0] id, output int n);
    logic [31:0] v;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      rd(id, 4'h0, v);
      if (!v[31]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 4'h0, v); chk("R1 cmd", v, 0);
    rd(0, 4'h4, v); chk("R1 data", v, 0);
    rd(0, 4'h8, v); chk("R1 lock", v, 0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(1, 4'h8, 32'h20);
    rd(1, 4'h8, v); chk("R2 owner readback", v, 32'h20);
    rd(2, 4'h8, v); chk("R2 other reads 0", v, 0);
    wr(2, 4'h8, 32'h20);
    rd(2, 4'h8, v); chk("R2 no steal", v, 0);
    rd(1, 4'h8, v); chk("R2 owner kept", v, 32'h20);
    wr(2, 4'h8, 32'h0);
    rd(1, 4'h8, v); chk("R3 non-owner release ignored", v, 32'h20);
    wr(1, 4'h8, 32'h0);
    rd(1, 4'h8, v); chk("R3 owner released", v, 0);
    wr(0, 4'h8, 32'h20);
    rd(0, 4'h8, v); chk("R3 free after release", v, 32'h20);
  endtask

  task automatic t_write_read();
    logic [31:0] v; int n;
    dly = 8'd3;
    wr(0, 4'h4, 32'hA5);
    wr(0, 4'h0, 32'hB000_0010);
    poll(0, n); chk("R7 write busy cycles", n, 4);
    rd(0, 4'h0, v); chk("R12 write cmd readback", v, 32'h3000_0010);
    wr(0, 4'h4, 32'h0);
    wr(0, 4'h0, 32'h8000_0010);
    poll(0, n); chk("R7 read busy cycles", n, 4);
    rd(0, 4'h4, v); chk("R5 R6 read byte", v, 32'hA5);
    rd(0, 4'h0, v); chk("R12 read cmd readback", v, 32'h0000_0010);
    dly = 8'd0;
    wr(0, 4'h4, 32'hFFFF_FF3C);
    wr(0, 4'h0, 32'hB000_0000 | (MEM_BYTES - 1));
    poll(0, n); chk("R7 zero delay", n, 1);
    wr(0, 4'h0, 32'h8000_0000 | (MEM_BYTES - 1));
    poll(0, n);
    rd(0, 4'h4, v); chk("R6 zero upper bits", v, 32'h3C);
  endtask

  task automatic t_max_delay();
    logic [31:0] v; int n;
    dly = 8'(TOUT - 1);
    wr(0, 4'h0, 32'h8000_0010);
    poll(0, n); chk("R7 max delay cycles", n, TOUT);
    rd(0, 4'h0, v); chk("R7 no timeout", v[17], 0);
  endtask

  task automatic t_timeout();
    logic [31:0] v; int n;
    dly = 8'(TOUT);
    wr(0, 4'h4, 32'hFF);
    wr(0, 4'h0, 32'hB000_0010);
    poll(0, n); chk("R8 timeout cycles", n, TOUT);
    rd(0, 4'h0, v); chk("R8 timeout flag", v, 32'h3002_0010);
    dly = 8'd1;
    wr(0, 4'h0, 32'h8000_0010);
    poll(0, n);
    rd(0, 4'h4, v); chk("R8 array unchanged", v, 32'hA5);
    rd(0, 4'h0, v); chk("R9 flag sticky", v[17], 1);
    wr(0, 4'h0, 32'h0002_0010);
    rd(0, 4'h0, v); chk("R9 flag cleared", v[17], 0);
    present = 1'b0;
    wr(0, 4'h0, 32'h8000_0010);
    poll(0, n); chk("R8 absent cycles", n, TOUT);
    rd(0, 4'h0, v); chk("R8 absent flag", v[17], 1);
    present = 1'b1;
    wr(0, 4'h0, 32'h0002_0000 | MEM_BYTES);
    wr(0, 4'h0, 32'h8000_0000 | MEM_BYTES);
    poll(0, n); chk("R11 out of range cycles", n, TOUT);
    rd(0, 4'h0, v); chk("R11 out of range flag", v[17], 1);
    wr(0, 4'h0, 32'h0002_0010);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v; int n;
    dly = 8'd10;
    wr(0, 4'h0, 32'h8000_0010);
    wr(0, 4'h4, 32'h77);
    wr(0, 4'h0, 32'hB000_0020);
    poll(0, n);
    rd(0, 4'h4, v); chk("R10 data kept", v, 32'hA5);
    rd(0, 4'h0, v); chk("R10 cmd kept", v, 32'h0000_0010);
  endtask

  task automatic t_nolock();
    logic [31:0] v; int n;
    dly = 8'd0;
    wr(0, 4'h8, 32'h0);
    wr(1, 4'h4, 32'h5A);
    wr(1, 4'h0, 32'hB000_0010);
    rd(1, 4'h0, v); chk("R4 busy stays 0", v[31], 0);
    rd(1, 4'h4, v); chk("R4 data untouched", v, 32'hA5);
    wr(1, 4'h8, 32'h20);
    wr(1, 4'h4, 32'h0);
    wr(1, 4'h0, 32'h8000_0010);
    poll(1, n);
    rd(1, 4'h4, v); chk("R4 array untouched", v, 32'hA5);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_write_read();
    t_max_delay();
    t_timeout();
    t_busy_ignore();
    t_nolock();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule